// File: doc/BRIEF.md
# Folded biquad filter datapath

A second-order recursive filter that computes four additions and four multiplications per sample with one adder and one two-stage multiplier. A free-running slot counter divides time into four-cycle iterations. In each slot the counter selects which operands the adder and the multiplier take and which coefficient goes to the multiplier. The graph behind the schedule is a retimed biquad in which every delay count is zero or positive. Values that have to outlive one slot sit in three storage registers: two copies of the recursive state and one register that holds a product.

The block takes one sample per iteration and gives one result per iteration, marked by a one-cycle strobe. The four coefficients are signed fixed-point parameters with `FRAC` fraction bits. Products are shifted right arithmetically, which rounds toward minus infinity, and then cut to the data width. All sums wrap modulo 2^DW. Iteration l covers cycles 4l to 4l+3, counted from the first cycle after reset is released. Slot s is the cycle 4l+s.

Top module: `folded_biquad`

## Requirements
- R1: A synchronous reset clears the slot counter and every register. In the first cycle after reset `y_out` is 0 and `y_valid` is 0.
- R2: `y_valid` is high only in slot 2 and is high in slot 2 of every iteration from iteration 1 onwards (first pulse at cycle 6). It is high for exactly one cycle in four.
- R3: `x_in` is sampled only at the clock edge that ends slot 3. Its value in slots 0, 1 and 2 has no effect on any output.
- R4: State recursion: w(l) = x(l) + T(A1·w(l-1)) + T(A2·w(l-2)), with w(k) = 0 for k < 0. Here x(l) is `x_in` in slot 3 of iteration l.
- R5: Output: in slot 2 of iteration l, `y_out` = w(l-1) + T(B1·w(l-2)) + T(B2·w(l-3)). Through the retiming, the feed-forward branch lags the recursion by one iteration.
- R6: T(p) shifts the full-width signed product right arithmetically by `FRAC` bits and keeps the low DW bits. For example, −1·8192 with FRAC = 14 gives −1, not 0.
- R7: Every addition wraps modulo 2^DW in two's complement, with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | DW | Signed input sample, taken in slot 3 |
| y_out | output | DW | Signed filter output, meaningful while `y_valid` is high |
| y_valid | output | 1 | One-cycle strobe that marks a new output sample |

## Verification
An impulse shows the impulse response, which exposes a wrong slot pairing of any coefficient with a state delay. A constant step settles to the DC gain and catches a wrong sign or scale in the feedback products. An alternating sequence is tried twice, once with garbage on `x_in` outside slot 3, to show that only the slot-3 value matters. A large constant drives the state past full scale to check wrap-around, and small negative inputs show whether the products round toward minus infinity rather than toward zero.

// File: rtl/folded_biquad_pkg.sv
package folded_biquad_pkg;

    localparam int unsigned FOLD = 4;

    // Slots are named after the addition the adder performs in them.
    typedef enum logic [1:0] {
        SL_FWD_SUM   = 2'd0,   // feed-forward partial sum
        SL_OUT_SUM   = 2'd1,   // output sum
        SL_FB_SUM    = 2'd2,   // feedback partial sum
        SL_STATE_SUM = 2'd3    // new state = input + feedback
    } slot_e;

    typedef enum logic [1:0] { AA_MUL, AA_W1, AA_XIN } add_a_e;
    typedef enum logic       { AB_HOLD, AB_SUM }       add_b_e;
    typedef enum logic [1:0] { MA_SUM, MA_W1, MA_W2 }  mul_a_e;
    typedef enum logic [1:0] { CF_A1, CF_A2, CF_B1, CF_B2 } coef_e;

    typedef struct packed {
        add_a_e add_a;
        add_b_e add_b;
        mul_a_e mul_a;
        coef_e  coef;
        logic   load_w;
        logic   out_slot;
    } route_t;

    function automatic route_t route_for(slot_e s);
        route_t r;
        r = '{add_a: AA_MUL, add_b: AB_HOLD, mul_a: MA_SUM, coef: CF_A1,
              load_w: 1'b0, out_slot: 1'b0};
        case (s)
            SL_FWD_SUM: begin
                r.add_a  = AA_MUL;  r.add_b = AB_HOLD;
                r.mul_a  = MA_SUM;  r.coef  = CF_A1;
                r.load_w = 1'b1;
            end
            SL_OUT_SUM: begin
                r.add_a = AA_W1;    r.add_b = AB_SUM;
                r.mul_a = MA_W2;    r.coef  = CF_B2;
            end
            SL_FB_SUM: begin
                r.add_a    = AA_MUL; r.add_b = AB_HOLD;
                r.mul_a    = MA_W1;  r.coef  = CF_B1;
                r.out_slot = 1'b1;
            end
            default: begin
                r.add_a = AA_XIN;   r.add_b = AB_SUM;
                r.mul_a = MA_W1;    r.coef  = CF_A2;
            end
        endcase
        return r;
    endfunction

    function automatic slot_e next_slot(slot_e s);
        return slot_e'(2'(s + 2'd1));
    endfunction

endpackage

// File: rtl/fb_slot_ctrl.sv
module fb_slot_ctrl
    import folded_biquad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output logic  primed
);

    slot_e slot_q;
    logic  primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= SL_FWD_SUM;
            primed_q <= 1'b0;
        end else begin
            slot_q <= next_slot(slot_q);
            if (slot_q == SL_STATE_SUM)
                primed_q <= 1'b1;
        end
    end

    assign slot   = slot_q;
    assign primed = primed_q;

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        slot_q == SL_STATE_SUM |=> slot_q == SL_FWD_SUM); // R2

    AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (rst)
        primed_q |=> primed_q); // R2

endmodule

// File: rtl/fb_mult_pipe.sv
module fb_mult_pipe #(
    parameter int unsigned DW   = 16,
    parameter int unsigned CW   = 16,
    parameter int unsigned FRAC = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opnd,
    input  logic [CW-1:0] coef,
    output logic [DW-1:0] prod
);

    localparam int unsigned PW = DW + CW;

    logic signed [PW-1:0] full_q;
    logic        [DW-1:0] prod_q;
    logic        [1:0]    age_q;

    // stage 1: full-precision product; stage 2: scale and cut to DW
    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
            prod_q <= '0;
            age_q  <= '0;
        end else begin
            full_q <= PW'($signed(opnd)) * PW'($signed(coef));
            prod_q <= DW'(full_q >>> FRAC);
            if (age_q != 2'd2)
                age_q <= age_q + 2'd1;
        end
    end

    assign prod = prod_q;

    AST_MUL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && ($past(opnd, 2) == '0 || $past(coef, 2) == '0))
        |-> prod_q == '0); // R6

endmodule

// File: rtl/fb_delay_regs.sv
module fb_delay_regs #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_w,
    input  logic [DW-1:0] sum_in,
    input  logic [DW-1:0] prod_in,
    output logic [DW-1:0] w1,
    output logic [DW-1:0] w2,
    output logic [DW-1:0] hold
);

    logic [DW-1:0] w1_q, w2_q, hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w1_q   <= '0;
            w2_q   <= '0;
            hold_q <= '0;
        end else begin
            hold_q <= prod_in;
            if (load_w) begin
                w1_q <= sum_in;
                w2_q <= w1_q;
            end
        end
    end

    assign w1   = w1_q;
    assign w2   = w2_q;
    assign hold = hold_q;

    AST_W1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_w |=> $stable(w1_q)); // R4

    AST_W2_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_w |=> $stable(w2_q)); // R5

endmodule

// File: rtl/folded_biquad.sv
module folded_biquad
    import folded_biquad_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned CW   = 16,
    parameter int unsigned FRAC = 14,
    parameter logic signed [CW-1:0] A1 = 16'sd8192,
    parameter logic signed [CW-1:0] A2 = -16'sd4096,
    parameter logic signed [CW-1:0] B1 = 16'sd12288,
    parameter logic signed [CW-1:0] B2 = -16'sd6144
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] x_in,
    output logic [DW-1:0] y_out,
    output logic          y_valid
);

    slot_e         slot;
    logic          primed;
    route_t        rt;
    logic [DW-1:0] sum_q;
    logic [DW-1:0] add_a, add_b, mul_a;
    logic [CW-1:0] mul_c;
    logic [DW-1:0] prod, w1, w2, hold;

    fb_slot_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot),
        .primed (primed)
    );

    assign rt = route_for(slot);

    always_comb begin
        case (rt.add_a)
            AA_MUL:  add_a = prod;
            AA_W1:   add_a = w1;
            default: add_a = x_in;
        endcase
        add_b = (rt.add_b == AB_HOLD) ? hold : sum_q;
        case (rt.mul_a)
            MA_SUM:  mul_a = sum_q;
            MA_W1:   mul_a = w1;
            default: mul_a = w2;
        endcase
        case (rt.coef)
            CF_A1:   mul_c = A1;
            CF_A2:   mul_c = A2;
            CF_B1:   mul_c = B1;
            default: mul_c = B2;
        endcase
    end

    // single-stage adder shared by all four additions
    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= add_a + add_b;
    end

    fb_mult_pipe #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mult (
        .clk  (clk),
        .rst  (rst),
        .opnd (mul_a),
        .coef (mul_c),
        .prod (prod)
    );

    fb_delay_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .load_w  (rt.load_w),
        .sum_in  (sum_q),
        .prod_in (prod),
        .w1      (w1),
        .w2      (w2),
        .hold    (hold)
    );

    assign y_out   = sum_q;
    assign y_valid = rt.out_slot & primed;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !y_valid)); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid); // R2

    AST_VALID_PERIOD: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> ##4 y_valid); // R2

endmodule

// File: tb/folded_biquad_bench.sv
`timescale 1ns/1ps
module folded_biquad_bench;
    localparam int DW = 16, CW = 16, FRAC = 14, NITER = 14;
    localparam longint KA1 = 8192, KA2 = -4096, KB1 = 12288, KB2 = -6144;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] x_in = '0;
    logic [DW-1:0] y_out;
    logic          y_valid;

    int  checks = 0, errors = 0;
    bit  done = 1'b0;
    longint xs [0:NITER-1];
    longint ws [0:NITER-1];

    folded_biquad #(.DW(DW), .CW(CW), .FRAC(FRAC),
        .A1(16'sd8192), .A2(-16'sd4096), .B1(16'sd12288), .B2(-16'sd6144))
    u_folded_biquad (.clk(clk), .rst(rst), .x_in(x_in), .y_out(y_out), .y_valid(y_valid));

    always #2.5 clk = ~clk;

    function automatic longint wrap(longint v);
        longint m;
        m = v & ((64'sd1 <<< DW) - 1);
        if (m >= (64'sd1 <<< (DW - 1))) m = m - (64'sd1 <<< DW);
        return m;
    endfunction

    function automatic longint tmul(longint w, longint c);
        return wrap((w * c) >>> FRAC);
    endfunction

    function automatic longint w_at(int i);
        return (i < 0) ? 64'sd0 : ws[i];
    endfunction

    function automatic longint pattern(int kind, int l);
        case (kind)
            0: return (l == 0) ? 64'sd8000 : 64'sd0;
            1: return 64'sd4000;
            2: return (l % 2 == 0) ? 64'sd6000 : -64'sd6000;
            3: return 64'sd30000;
            default: return (l % 3 == 0) ? -64'sd3 : -64'sd1;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        x_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_case(string tag, int kind, bit noisy);
        for (int l = 0; l < NITER; l++) begin
            xs[l] = pattern(kind, l);
            ws[l] = wrap(xs[l] + tmul(w_at(l - 1), KA1) + tmul(w_at(l - 2), KA2));
        end
        do_reset();
        check("R1 y_out after reset", longint'($signed(y_out)), 0);
        check("R1 y_valid after reset", longint'(y_valid), 0);
        for (int k = 0; k < 4 * NITER; k++) begin
            int l = k / 4;
            int s = k % 4;
            bit exp_v = (s == 2) && (k >= 6);
            if (s == 3 || !noisy) x_in = xs[l][DW-1:0];
            else                  x_in = DW'((k * 7919 + 12345) & 16'hFFFF);
            check("R2 y_valid strobe", longint'(y_valid), longint'(exp_v));
            if (exp_v) begin
                longint ey = wrap(w_at(l - 1) + tmul(w_at(l - 2), KB1)
                                  + tmul(w_at(l - 3), KB2));
                check(tag, longint'($signed(y_out)), ey);
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic midstream_reset();
        do_reset();
        for (int k = 0; k < 9; k++) begin
            x_in = DW'(16'd9000 + k);
            @(negedge clk);
        end
        do_reset();
        check("R1 y_out after mid-run reset", longint'($signed(y_out)), 0);
        check("R1 y_valid after mid-run reset", longint'(y_valid), 0);
        @(negedge clk); @(negedge clk);
        check("R1 no stale strobe in slot 2", longint'(y_valid), 0);
    endtask

    initial begin
        run_case("R4 impulse response", 0, 1'b0);
        run_case("R5 step response", 1, 1'b0);
        run_case("R5 alternating input", 2, 1'b0);
        run_case("R3 alternating with noise outside slot 3", 2, 1'b1);
        run_case("R7 wrap on large input", 3, 1'b0);
        run_case("R6 floor truncation of negatives", 4, 1'b0);
        midstream_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

endmodule